// File: doc/BRIEF.md
# Register-Direct ALU Instruction Executor

This block executes one register-to-register instruction from a 32-bit subset of a byte-coded two-operand instruction set. Each instruction is offered in one cycle as a first opcode byte, a second byte that counts only after the 0x0F escape, and an operand-selector byte. The operand-selector byte names two registers of an eight-entry register file. The block reads both registers, computes the result, writes it back and, for the arithmetic and logic operations, updates three status bits: sign (SF), zero (ZF) and signed overflow (OF).

One cycle after `start`, `done` pulses for one cycle. An instruction the block cannot execute raises `illegal` together with `done`, and then nothing in the machine state changes. A load port writes a register directly, so the caller can set operands up. A combinational read port returns any register, so the caller can see results.

Top module: `reg_alu_exec`

## Requirements
- R1: The operand-selector byte holds the mode in bits 7:6, the source/auxiliary field in bits 5:3 and the destination field in bits 2:0. Register index k selects entry k (0 to 7). Every opcode that uses the selector byte is accepted only with mode 3; any other mode makes the instruction illegal.
- R2: Opcodes 0x01 (add), 0x29 (subtract, destination minus source), 0x21 (AND), 0x09 (OR) and 0x31 (XOR) write the result of destination OP source into the destination register.
- R3: Add and subtract set SF to result bit 31 and ZF when the result is zero. They set OF when the signed 32-bit result differs from the exact signed difference or sum.
- R4: AND, OR and XOR set SF and ZF from the result and clear OF.
- R5: Opcode 0x39 (compare) sets SF, ZF and OF as subtract would for destination minus source, and writes no register.
- R6: Opcode 0x89 copies the source register into the destination register. Opcode 0x87 swaps the two registers in one instruction. Neither changes the flags.
- R7: The byte pair 0x0F 0xAF writes the low 32 bits of source-field register times destination-field register into the source-field register, with flags unchanged.
- R8: Opcodes 0x40 to 0x47 increment, and 0x48 to 0x4F decrement, the register indexed by opcode bits 2:0, modulo 2^32. They ignore the selector byte and leave the flags unchanged.
- R9: Opcode 0xFF increments the destination register when the source field is 0 and decrements it when the source field is 1, with flags unchanged. Any other source-field value is illegal.
- R10: An unknown first opcode, a second byte other than 0xAF after 0x0F, or any other illegal case raises `illegal` together with `done`, and leaves all registers and flags unchanged.
- R11: `done` is high exactly in the cycle after each cycle in which `start` is high.
- R12: After reset all registers and flags are zero, and `done` and `illegal` are low.
- R13: A load writes `ld_data` into register `ld_idx` at the clock edge. `rd_data` shows register `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Execute the instruction on the opcode inputs this cycle |
| op0 | input | 8 | First opcode byte |
| op1 | input | 8 | Second opcode byte, used after the 0x0F escape |
| modrm | input | 8 | Operand-selector byte |
| ld_en | input | 1 | Direct register load enable |
| ld_idx | input | 3 | Register index for the load |
| ld_data | input | DATA_W | Value to load |
| rd_idx | input | 3 | Register index for the read port |
| rd_data | output | DATA_W | Contents of register rd_idx |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Instruction was rejected (valid with done) |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| of | output | 1 | Overflow flag |

## Verification
The assertions assume that `ld_en` is never high in the same cycle as `start`. Without that, the checks that registers stay unchanged after an illegal or compare instruction would fail, because a load would alter the file. The state checks also exempt any cycle that follows a load. The stimulus keeps to this rule: every load and every instruction runs in its own task, which drives one cycle of activity and then idles for one cycle. The opcode and selector inputs are always driven to known values, so the checks that look at opcode bits never see unknowns.

// File: rtl/rax_pkg.sv
`timescale 1ns/1ps
package rax_pkg;
  localparam int IDX_W = 3;
  localparam int NREG  = 1 << IDX_W;

  localparam logic [7:0] OPC_ADD  = 8'h01;
  localparam logic [7:0] OPC_OR   = 8'h09;
  localparam logic [7:0] OPC_ESC  = 8'h0F;
  localparam logic [7:0] OPC_AND  = 8'h21;
  localparam logic [7:0] OPC_SUB  = 8'h29;
  localparam logic [7:0] OPC_XOR  = 8'h31;
  localparam logic [7:0] OPC_CMP  = 8'h39;
  localparam logic [7:0] OPC_XCHG = 8'h87;
  localparam logic [7:0] OPC_MOV  = 8'h89;
  localparam logic [7:0] OPC_GRP  = 8'hFF;
  localparam logic [7:0] OPC_MUL2 = 8'hAF;

  typedef enum logic [3:0] {
    ALU_NONE, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_CMP,
    ALU_MOV, ALU_XCHG, ALU_MUL, ALU_INC, ALU_DEC
  } alu_op_e;

  typedef struct packed {
    alu_op_e          op;
    logic [IDX_W-1:0] a_idx;  // first operand, primary write target
    logic [IDX_W-1:0] b_idx;  // second operand, swap target
    logic             bad;
  } dec_t;
endpackage

// File: rtl/rax_decode.sv
`timescale 1ns/1ps
module rax_decode
  import rax_pkg::*;
(
  input  logic [7:0] op0,
  input  logic [7:0] op1,
  input  logic [7:0] modrm,
  output dec_t       dec
);
  logic             mode_ok;
  logic             uses_sel;
  logic [IDX_W-1:0] fld_src;
  logic [IDX_W-1:0] fld_dst;

  assign mode_ok = (modrm[7:6] == 2'b11);
  assign fld_src = modrm[5:3];
  assign fld_dst = modrm[2:0];

  always_comb begin
    dec.op    = ALU_NONE;
    dec.a_idx = fld_dst;
    dec.b_idx = fld_src;
    uses_sel  = 1'b1;
    case (op0)
      OPC_ADD:  dec.op = ALU_ADD;
      OPC_SUB:  dec.op = ALU_SUB;
      OPC_AND:  dec.op = ALU_AND;
      OPC_OR:   dec.op = ALU_OR;
      OPC_XOR:  dec.op = ALU_XOR;
      OPC_CMP:  dec.op = ALU_CMP;
      OPC_MOV:  dec.op = ALU_MOV;
      OPC_XCHG: dec.op = ALU_XCHG;
      OPC_ESC: begin
        // the product lands in the source-field register
        dec.a_idx = fld_src;
        dec.b_idx = fld_dst;
        if (op1 == OPC_MUL2) dec.op = ALU_MUL;
      end
      OPC_GRP: begin
        if (fld_src == 3'd0)      dec.op = ALU_INC;
        else if (fld_src == 3'd1) dec.op = ALU_DEC;
      end
      default: begin
        if (op0[7:4] == 4'h4) begin
          uses_sel  = 1'b0;
          dec.a_idx = op0[IDX_W-1:0];
          dec.op    = op0[3] ? ALU_DEC : ALU_INC;
        end
      end
    endcase
    dec.bad = (dec.op == ALU_NONE) || (uses_sel && !mode_ok);
  end
endmodule

// File: rtl/rax_alu.sv
`timescale 1ns/1ps
module rax_alu
  import rax_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res_a,
  output logic [DATA_W-1:0] res_b,
  output logic              wr_a,
  output logic              wr_b,
  output logic              flg_upd,
  output logic              sf_n,
  output logic              zf_n,
  output logic              of_n
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] prod;
  logic [DATA_W-1:0] fval;

  assign sum  = a + b;
  assign diff = a - b;
  assign prod = a * b;

  always_comb begin
    res_a   = a;
    res_b   = a;
    wr_a    = 1'b0;
    wr_b    = 1'b0;
    flg_upd = 1'b0;
    of_n    = 1'b0;
    fval    = a;
    case (op)
      ALU_ADD: begin
        res_a = sum; wr_a = 1'b1; flg_upd = 1'b1; fval = sum;
        of_n  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      end
      ALU_SUB, ALU_CMP: begin
        res_a = diff; wr_a = (op == ALU_SUB); flg_upd = 1'b1; fval = diff;
        of_n  = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
      end
      ALU_AND: begin res_a = a & b; wr_a = 1'b1; flg_upd = 1'b1; fval = a & b; end
      ALU_OR:  begin res_a = a | b; wr_a = 1'b1; flg_upd = 1'b1; fval = a | b; end
      ALU_XOR: begin res_a = a ^ b; wr_a = 1'b1; flg_upd = 1'b1; fval = a ^ b; end
      ALU_MOV:  begin res_a = b; wr_a = 1'b1; end
      ALU_XCHG: begin res_a = b; res_b = a; wr_a = 1'b1; wr_b = 1'b1; end
      ALU_MUL:  begin res_a = prod; wr_a = 1'b1; end
      ALU_INC:  begin res_a = a + ONE; wr_a = 1'b1; end
      ALU_DEC:  begin res_a = a - ONE; wr_a = 1'b1; end
      default: ;
    endcase
    sf_n = fval[MSB];
    zf_n = (fval == '0);
  end
endmodule

// File: rtl/rax_regfile.sv
`timescale 1ns/1ps
module rax_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int IDX_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_a,
  input  logic [IDX_W-1:0]       wa_idx,
  input  logic [DATA_W-1:0]      wa_data,
  input  logic                   we_b,
  input  logic [IDX_W-1:0]       wb_idx,
  input  logic [DATA_W-1:0]      wb_data,
  input  logic                   ld_en,
  input  logic [IDX_W-1:0]       ld_idx,
  input  logic [DATA_W-1:0]      ld_data,
  input  logic [IDX_W-1:0]       ra_idx,
  input  logic [IDX_W-1:0]       rb_idx,
  input  logic [IDX_W-1:0]       rc_idx,
  output logic [DATA_W-1:0]      ra_data,
  output logic [DATA_W-1:0]      rb_data,
  output logic [DATA_W-1:0]      rc_data,
  output logic [NREG*DATA_W-1:0] all_q
);
  logic [DATA_W-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic              en;
    logic [DATA_W-1:0] d;
    always_comb begin
      en = 1'b0;
      d  = q[i];
      if (ld_en && ld_idx == IDX_W'(i)) begin en = 1'b1; d = ld_data; end
      if (we_a && wa_idx == IDX_W'(i))  begin en = 1'b1; d = wa_data; end
      if (we_b && wb_idx == IDX_W'(i))  begin en = 1'b1; d = wb_data; end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= '0;
      else if (en) q[i] <= d;
    end
    assign all_q[i*DATA_W +: DATA_W] = q[i];
  end

  assign ra_data = q[ra_idx];
  assign rb_data = q[rb_idx];
  assign rc_data = q[rc_idx];
endmodule

// File: rtl/reg_alu_exec.sv
`timescale 1ns/1ps
module reg_alu_exec
  import rax_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        op0,
  input  logic [7:0]        op1,
  input  logic [7:0]        modrm,
  input  logic              ld_en,
  input  logic [2:0]        ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [2:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              illegal,
  output logic              sf,
  output logic              zf,
  output logic              of
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  dec_t              dec;
  logic [DATA_W-1:0] opa, opb;
  logic [DATA_W-1:0] res_a, res_b;
  logic              wr_a, wr_b, flg_upd, sf_n, zf_n, of_n;
  logic              exec_en;
  logic [NREG*DATA_W-1:0] rf_all;

  rax_decode u_dec (.op0(op0), .op1(op1), .modrm(modrm), .dec(dec));

  rax_alu #(.DATA_W(DATA_W)) u_alu (
    .op(dec.op), .a(opa), .b(opb), .res_a(res_a), .res_b(res_b),
    .wr_a(wr_a), .wr_b(wr_b), .flg_upd(flg_upd),
    .sf_n(sf_n), .zf_n(zf_n), .of_n(of_n)
  );

  assign exec_en = start && !dec.bad;

  rax_regfile #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_i_n),
    .we_a(exec_en && wr_a), .wa_idx(dec.a_idx), .wa_data(res_a),
    .we_b(exec_en && wr_b), .wb_idx(dec.b_idx), .wb_data(res_b),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .ra_idx(dec.a_idx), .rb_idx(dec.b_idx), .rc_idx(rd_idx),
    .ra_data(opa), .rb_data(opb), .rc_data(rd_data), .all_q(rf_all)
  );

  // flag next state
  logic [2:0] flg_d, flg_q;
  logic       flg_en;
  assign flg_en = exec_en && flg_upd;
  assign flg_d  = {sf_n, zf_n, of_n};

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    flg_q <= 3'b000;
    else if (flg_en) flg_q <= flg_d;
  end
  assign {sf, zf, of} = flg_q;

  // completion status
  logic done_d, ill_d, done_q, ill_q;
  assign done_d = start;
  assign ill_d  = start && dec.bad;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      ill_q  <= ill_d;
    end
  end
  assign done    = done_q;
  assign illegal = ill_q;
endmodule

// File: rtl/reg_alu_exec_chk.sv
`timescale 1ns/1ps
module reg_alu_exec_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [7:0]        op0,
  input logic [7:0]        modrm,
  input logic              ld_en,
  input logic              done,
  input logic              illegal,
  input logic              sf,
  input logic              zf,
  input logic              of,
  input logic [8*DATA_W-1:0] rf_all
);
  assert_done_after_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  assert_done_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));

  assert_illegal_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  assert_illegal_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !$past(ld_en)) |-> ($stable(rf_all) && $stable({sf, zf, of})));

  assert_incdec_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op0[7:4] == 4'h4) |=> $stable({sf, zf, of}));

  assert_logic_clears_of_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && modrm[7:6] == 2'b11 && (op0 == 8'h21 || op0 == 8'h09 || op0 == 8'h31)) |=> !of);

  assert_compare_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op0 == 8'h39 && !ld_en) |=> $stable(rf_all));
endmodule

bind reg_alu_exec reg_alu_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op0(op0), .modrm(modrm),
  .ld_en(ld_en), .done(done), .illegal(illegal),
  .sf(sf), .zf(zf), .of(of), .rf_all(rf_all)
);

// File: tb/sim_reg_alu_exec.sv
`timescale 1ns/1ps
module sim_reg_alu_exec;
  localparam int CLK_HALF = 2;  // 250 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op0 = 8'h00, op1 = 8'h00, modrm = 8'h00;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_idx = 3'd0;
  logic [31:0] ld_data = 32'd0;
  logic [2:0]  rd_idx = 3'd0;
  logic [31:0] rd_data;
  logic        done, illegal, sf, zf, of;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #CLK_HALF clk = ~clk;

  reg_alu_exec u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op0(op0), .op1(op1), .modrm(modrm),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .rd_idx(rd_idx),
    .rd_data(rd_data), .done(done), .illegal(illegal), .sf(sf), .zf(zf), .of(of)
  );

  // reference state built from the requirements
  logic [31:0] m [8];
  logic        m_sf, m_zf, m_of;

  typedef struct {
    string       tag;
    logic        ill;
    logic        sf, zf, of;
    logic [2:0]  idx;
    logic [31:0] val;
  } exp_t;
  exp_t sb[$];
  exp_t e;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void arith(input logic [31:0] r, input longint exact);
    m_sf = r[31];
    m_zf = (r == 32'd0);
    m_of = (longint'($signed(r)) != exact);
  endfunction

  function automatic void logic_flags(input logic [31:0] r);
    m_sf = r[31];
    m_zf = (r == 32'd0);
    m_of = 1'b0;
  endfunction

  task automatic load(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_data = val;
    m[idx] = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // driver: issue one instruction and queue what the monitor must see
  task automatic run_op(input string tag, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] sel, input logic [2:0] idx);
    logic [1:0]  md = sel[7:6];
    logic [2:0]  rg = sel[5:3];
    logic [2:0]  rm = sel[2:0];
    logic [31:0] a = m[rm];
    logic [31:0] b = m[rg];
    logic [31:0] r;
    logic        ill = 1'b0;
    longint      sa = longint'($signed(a));
    longint      sb_v = longint'($signed(b));
    exp_t        it;
    if (b0 inside {[8'h40:8'h47]})      m[b0[2:0]] = m[b0[2:0]] + 32'd1;
    else if (b0 inside {[8'h48:8'h4F]}) m[b0[2:0]] = m[b0[2:0]] - 32'd1;
    else if (md != 2'b11) ill = 1'b1;
    else begin
      case (b0)
        8'h01: begin r = a + b; arith(r, sa + sb_v); m[rm] = r; end
        8'h29: begin r = a - b; arith(r, sa - sb_v); m[rm] = r; end
        8'h39: begin r = a - b; arith(r, sa - sb_v); end
        8'h21: begin r = a & b; logic_flags(r); m[rm] = r; end
        8'h09: begin r = a | b; logic_flags(r); m[rm] = r; end
        8'h31: begin r = a ^ b; logic_flags(r); m[rm] = r; end
        8'h89: m[rm] = b;
        8'h87: begin m[rm] = b; m[rg] = a; end
        8'h0F: if (b1 == 8'hAF) m[rg] = b * a; else ill = 1'b1;
        8'hFF: begin
          if (rg == 3'd0)      m[rm] = a + 32'd1;
          else if (rg == 3'd1) m[rm] = a - 32'd1;
          else ill = 1'b1;
        end
        default: ill = 1'b1;
      endcase
    end
    it.tag = tag; it.ill = ill; it.sf = m_sf; it.zf = m_zf; it.of = m_of;
    it.idx = idx; it.val = m[idx];
    @(negedge clk);
    start = 1'b1; op0 = b0; op1 = b1; modrm = sel; rd_idx = idx;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compare each completion against the queue (R11 via done timing)
  always @(posedge clk) begin
    #1;
    if (done) begin
      if (sb.size() == 0) begin
        checks++; failures++;
        $display("FAIL R11 done with nothing pending actual=1 expected=0");
      end else begin
        e = sb.pop_front();
        check({e.tag, " illegal"}, {31'd0, illegal}, {31'd0, e.ill});
        check({e.tag, " flags"}, {29'd0, sf, zf, of}, {29'd0, e.sf, e.zf, e.of});
        check({e.tag, " reg"}, rd_data, e.val);
      end
    end
  end

  task automatic sweep(input string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rd_idx = 3'(i);
      #1;
      check({tag, " R13 register sweep"}, rd_data, m[i]);
    end
  endtask

  initial begin
    #(CLK_HALF * 2 * 60000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 32'd0;
    m_sf = 1'b0; m_zf = 1'b0; m_of = 1'b0;
    #(CLK_HALF * 2 * 5 + 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state
    check("R12 done", {31'd0, done}, 32'd0);
    check("R12 illegal", {31'd0, illegal}, 32'd0);
    check("R12 flags", {29'd0, sf, zf, of}, 32'd0);
    sweep("R12");

    // R13 load, R2/R3 add (sel D8: mode 3, src 3, dst 0)
    load(3'd0, 32'h10); load(3'd3, 32'h1);
    run_op("R2 R3 add", 8'h01, 8'h00, 8'hD8, 3'd0);
    load(3'd0, 32'd10);
    run_op("R2 R3 sub", 8'h29, 8'h00, 8'hD8, 3'd0);
    load(3'd0, 32'h8000_0000);
    run_op("R3 sub overflow", 8'h29, 8'h00, 8'hD8, 3'd0);
    load(3'd0, 32'h7FFF_FFFF);
    run_op("R3 add overflow", 8'h01, 8'h00, 8'hD8, 3'd0);
    load(3'd0, 32'hFFFF_FFFF);
    run_op("R3 add zero", 8'h01, 8'h00, 8'hD8, 3'd0);

    // R4 logic
    load(3'd0, 32'h0A0B_0C0D); load(3'd3, 32'h0000_00FF);
    run_op("R2 R4 and", 8'h21, 8'h00, 8'hD8, 3'd0);
    load(3'd0, 32'h0A0B_0C0D); load(3'd3, 32'hA0B0_C0D0);
    run_op("R2 R4 or", 8'h09, 8'h00, 8'hD8, 3'd0);
    load(3'd0, 32'h0A0B_0C0D); load(3'd3, 32'hAABB_C0D0);
    run_op("R2 R4 xor", 8'h31, 8'h00, 8'hD8, 3'd0);
    load(3'd1, 32'h5555_5555); load(3'd2, 32'h5555_5555);
    run_op("R4 xor zero", 8'h31, 8'h00, 8'hD1, 3'd2);

    // R5 compare: greater, lesser, equal, overflow
    load(3'd0, 32'h0A0B_0C0D); load(3'd3, 32'h0A0B_0C07);
    run_op("R5 cmp greater", 8'h39, 8'h00, 8'hD8, 3'd0);
    run_op("R5 cmp lesser", 8'h39, 8'h00, 8'hC3, 3'd3);
    load(3'd3, 32'h0A0B_0C0D);
    run_op("R5 cmp equal", 8'h39, 8'h00, 8'hD8, 3'd0);
    load(3'd0, 32'h8000_0000); load(3'd3, 32'h1);
    run_op("R5 cmp overflow", 8'h39, 8'h00, 8'hD8, 3'd0);

    // R6 copy and exchange
    load(3'd3, 32'hAF);
    run_op("R6 copy", 8'h89, 8'h00, 8'hD8, 3'd0);
    load(3'd0, 32'h2E);
    run_op("R6 exchange dst", 8'h87, 8'h00, 8'hD8, 3'd0);
    run_op("R6 exchange src", 8'h87, 8'h00, 8'hD8, 3'd3);

    // R7 multiply into source-field register
    load(3'd0, 32'd4); load(3'd3, 32'd2);
    run_op("R7 multiply", 8'h0F, 8'hAF, 8'hD8, 3'd3);
    load(3'd6, 32'hFFFF_FFFD); load(3'd7, 32'd5);
    run_op("R7 multiply signed", 8'h0F, 8'hAF, 8'hF7, 3'd6);

    // R8 short increment/decrement, with wrap; selector byte ignored
    load(3'd1, 32'h1F);
    run_op("R8 increment", 8'h41, 8'h00, 8'h00, 3'd1);
    run_op("R8 decrement", 8'h49, 8'h00, 8'h00, 3'd1);
    load(3'd5, 32'hFFFF_FFFF);
    run_op("R8 increment wrap", 8'h45, 8'h00, 8'h12, 3'd5);
    run_op("R8 decrement wrap", 8'h4D, 8'h00, 8'h00, 3'd5);

    // R9 group opcode
    load(3'd0, 32'h20);
    run_op("R9 group increment", 8'hFF, 8'h00, 8'hC0, 3'd0);
    run_op("R9 group decrement", 8'hFF, 8'h00, 8'hC8, 3'd0);
    run_op("R9 group bad subop", 8'hFF, 8'h00, 8'hD0, 3'd0);

    // R1 / R10 illegal cases leave state untouched
    run_op("R1 mode not 3", 8'h01, 8'h00, 8'h18, 3'd0);
    run_op("R1 group mode not 3", 8'hFF, 8'h00, 8'h40, 3'd0);
    run_op("R10 unknown opcode", 8'h00, 8'h00, 8'hD8, 3'd0);
    run_op("R10 bad escape byte", 8'h0F, 8'hAE, 8'hD8, 3'd3);

    repeat (3) @(negedge clk);
    check("R11 all completions seen", 32'(sb.size()), 32'd0);
    check("R10 flags after illegal", {29'd0, sf, zf, of}, {29'd0, m_sf, m_zf, m_of});
    sweep("R10 final");

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule